// File: doc/BRIEF.md
# Stacked and Rotating Register Renamer

This block translates the logical general-register number in an instruction into an index in a physical register file. The lowest 32 logical numbers are shared by every procedure and pass through unchanged. Numbers from 32 upward belong to the current procedure's frame. The frame sits at a sliding base in a circular pool of physical stacked registers. Inside the frame, a leading group of registers can be rotated. In that group the instruction's number is virtual and is offset by a rotating base, modulo the group's size.

Four single-cycle strobes drive the frame. Alloc sets the frame shape from three counts: locals, outputs and rotating. Call moves the base past the caller's locals, so the callee's frame holds only the caller's outputs. Return brings back the caller's frame exactly as it was. Rotate steps the rotating base down by one. A bounded save stack keeps one entry per nesting level. A call made when the stack is full is refused and raises an overflow flag, which a spill engine would service. A return made when the stack is empty is refused and raises an underflow flag, which a fill engine would service. The lookup path is purely combinational. The frame state updates on the clock edge that samples a strobe.

Top module: `regframe_renamer`

## Requirements
- R1: A logical index below 32 gives a physical index equal to itself and never raises the illegal-register flag.
- R2: After reset the frame size, frame base and rotating base are zero, the save stack is empty, and both stack flags are low.
- R3: Alloc sets frame size = locals + outputs, sets the rotating size and clears the rotating base. An alloc whose total exceeds 96, or whose rotating count exceeds that total, is ignored.
- R4: For a logical index i of 32 or more, let v = i - 32 and let r be v after any rotation. The physical index is then 32 + ((frame base + r) mod PHYS_STK).
- R5: Rotate decrements the rotating base and wraps from 0 to rotating size - 1. When the rotating size is 0 it has no effect. For v below the rotating size, r = (v + rotating base) mod rotating size. Otherwise r = v.
- R6: Call saves the frame and moves the base forward by the locals count, modulo PHYS_STK. The new frame size is the old size minus the locals. The new locals, rotating size and rotating base are all zero.
- R7: Return restores the frame base, frame size, locals, rotating size and rotating base that were in force before the matching call.
- R8: A call made when SAVE_DEPTH frames are already saved raises stack_overflow and leaves the frame unchanged.
- R9: A return made with nothing saved raises stack_underflow and leaves the frame unchanged.
- R10: A logical index i of 32 or more with i - 32 >= frame size raises illegal_reg.
- R11: When several strobes are high together, only one takes effect. The priority order is alloc, then call, then return, then rotate.
- R12: Each stack flag is high only in the cycle that follows the clock edge sampling the refused command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| do_alloc | input | 1 | Alloc strobe |
| do_call | input | 1 | Call strobe |
| do_return | input | 1 | Return strobe |
| do_rotate | input | 1 | Loop-branch rotate strobe |
| alloc_locals | input | 7 | Locals count for alloc |
| alloc_outputs | input | 7 | Outputs count for alloc |
| alloc_rotating | input | 7 | Rotating count for alloc |
| lookup_idx | input | 7 | Logical register index |
| phys_idx | output | $clog2(32+PHYS_STK) (8) | Physical register index |
| frame_size | output | 7 | Current frame size |
| illegal_reg | output | 1 | Index beyond the current frame |
| stack_overflow | output | 1 | Refused call, spill needed |
| stack_underflow | output | 1 | Refused return, fill needed |

## Verification
The outputs phys_idx, illegal_reg and frame_size depend combinationally on lookup_idx and the current frame state. A strobe therefore shows in them right after the clock edge that samples it. The stack flags pass through one register and rise after that same edge. They fall at the next edge unless another refused command arrives. The bench raises strobes on a falling edge and lets one rising edge pass. It then checks the flags and frame size on the next falling edge. Each lookup is changed on a falling edge and sampled a short delay later, well away from any rising edge.

// File: rtl/regframe_pkg.sv
// Shared constants and types for the register renamer.
// Assumes a fixed block of 32 global registers and a 7-bit logical index.
package regframe_pkg;
    localparam int NUM_GLOBALS = 32;
    localparam int LOG_W       = 7;
    localparam int CNT_W       = 7;
    localparam int MAX_FRAME   = 96;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ALLOC,
        CMD_CALL,
        CMD_RET,
        CMD_ROT
    } frame_cmd_e;

    typedef struct packed {
        cnt_t sof;   // frame size
        cnt_t sol;   // locals size
        cnt_t sor;   // rotating size
        cnt_t rrb;   // rotating base
    } frame_shape_t;
endpackage

// File: rtl/regframe_cmd_decode.sv
// Priority encoder for the frame command strobes.
// Assumes strobes are single-cycle; alloc > call > return > rotate.
module regframe_cmd_decode
    import regframe_pkg::*;
(
    input  logic       do_alloc,
    input  logic       do_call,
    input  logic       do_return,
    input  logic       do_rotate,
    output frame_cmd_e cmd
);
    // Pick the single command that takes effect this cycle.
    always_comb begin
        if (do_alloc)       cmd = CMD_ALLOC;
        else if (do_call)   cmd = CMD_CALL;
        else if (do_return) cmd = CMD_RET;
        else if (do_rotate) cmd = CMD_ROT;
        else                cmd = CMD_NONE;
    end
endmodule

// File: rtl/regframe_save_stack.sv
// LIFO of saved frames, one entry per call nesting level.
// Assumes push and pop are never requested in the same cycle.
module regframe_save_stack #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] count;
    logic [PTR_W-1:0] top_ptr;

    assign full    = (count == PTR_W'(DEPTH));
    assign empty   = (count == '0);
    assign top_ptr = count - PTR_W'(1);
    assign top_data = mem[top_ptr[IDX_W-1:0]];

    // Track the number of saved frames.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (push && !full) count <= count + PTR_W'(1);
        else if (pop && !empty) count <= count - PTR_W'(1);
    end

    // Store a frame on a successful push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[count[IDX_W-1:0]] <= push_data;
    end

    assert_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH));
endmodule

// File: rtl/regframe_ctrl.sv
// Holds the current frame (base, sizes, rotating base) and applies commands.
// Assumes PHYS_STK >= 96 so a frame never wraps onto itself.
module regframe_ctrl
    import regframe_pkg::*;
#(
    parameter int PHYS_STK = 128,
    parameter int DEPTH    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  frame_cmd_e                  cmd,
    input  cnt_t                        alloc_locals,
    input  cnt_t                        alloc_outputs,
    input  cnt_t                        alloc_rotating,
    output logic [$clog2(PHYS_STK)-1:0] frame_base,
    output cnt_t                        frame_sof,
    output cnt_t                        frame_sor,
    output cnt_t                        frame_rrb,
    output logic                        ovf_flag,
    output logic                        unf_flag
);
    localparam int BASE_W  = $clog2(PHYS_STK);
    localparam int SHAPE_W = $bits(frame_shape_t);
    localparam int ENTRY_W = BASE_W + SHAPE_W;
    localparam int SUM_W   = ((BASE_W > CNT_W) ? BASE_W : CNT_W) + 1;

    frame_shape_t        shape, shape_n, shape_saved;
    logic [BASE_W-1:0]   base_n, base_saved, callee_base;
    logic [ENTRY_W-1:0]  top_data;
    logic                stk_full, stk_empty, push, pop;
    logic [CNT_W:0]      alloc_total;
    logic                alloc_ok;
    logic [SUM_W-1:0]    base_sum;

    assign push = (cmd == CMD_CALL) && !stk_full;
    assign pop  = (cmd == CMD_RET) && !stk_empty;

    regframe_save_stack #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data ({frame_base, shape}),
        .top_data  (top_data),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    assign base_saved  = top_data[ENTRY_W-1 -: BASE_W];
    assign shape_saved = frame_shape_t'(top_data[SHAPE_W-1:0]);

    // Validate alloc sizes against the frame limit.
    always_comb begin
        alloc_total = {1'b0, alloc_locals} + {1'b0, alloc_outputs};
        alloc_ok    = (alloc_total <= (CNT_W+1)'(MAX_FRAME)) &&
                      ({1'b0, alloc_rotating} <= alloc_total);
    end

    // Callee base: current base plus locals, wrapped on the pool size.
    always_comb begin
        base_sum = SUM_W'(frame_base) + SUM_W'(shape.sol);
        if (base_sum >= SUM_W'(PHYS_STK))
            callee_base = BASE_W'(base_sum - SUM_W'(PHYS_STK));
        else
            callee_base = BASE_W'(base_sum);
    end

    // Next frame state for the selected command.
    always_comb begin
        base_n  = frame_base;
        shape_n = shape;
        case (cmd)
            CMD_ALLOC: if (alloc_ok) begin
                shape_n.sof = alloc_total[CNT_W-1:0];
                shape_n.sol = alloc_locals;
                shape_n.sor = alloc_rotating;
                shape_n.rrb = '0;
            end
            CMD_CALL: if (!stk_full) begin
                base_n      = callee_base;
                shape_n.sof = shape.sof - shape.sol;
                shape_n.sol = '0;
                shape_n.sor = '0;
                shape_n.rrb = '0;
            end
            CMD_RET: if (!stk_empty) begin
                base_n  = base_saved;
                shape_n = shape_saved;
            end
            CMD_ROT: if (shape.sor != '0) begin
                shape_n.rrb = (shape.rrb == '0) ? shape.sor - cnt_t'(1)
                                                : shape.rrb - cnt_t'(1);
            end
            default: ;
        endcase
    end

    // Register the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_base <= '0;
            shape      <= '0;
        end else begin
            frame_base <= base_n;
            shape      <= shape_n;
        end
    end

    // Register the refused-command flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= (cmd == CMD_CALL) && stk_full;
            unf_flag <= (cmd == CMD_RET) && stk_empty;
        end
    end

    assign frame_sof = shape.sof;
    assign frame_sor = shape.sor;
    assign frame_rrb = shape.rrb;

    assert_rrb_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shape.sor != '0) |-> (shape.rrb < shape.sor));
    assert_rrb_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shape.sor == '0) |-> (shape.rrb == '0));
    assert_alloc_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ALLOC && alloc_ok) |=>
            (shape.rrb == '0 && shape.sor == $past(alloc_rotating)));
    assert_call_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CALL && !stk_full) |=>
            (shape.sol == '0 && shape.sor == '0 && shape.rrb == '0));
    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> $past(cmd == CMD_CALL));
    assert_unf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> $past(cmd == CMD_RET));
    assert_refused_call_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CALL && stk_full) |=> $stable(frame_base));
    assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));
endmodule

// File: rtl/regframe_map.sv
// Combinational logical-to-physical index translation.
// Assumes rrb < sor whenever sor is non-zero, and base < PHYS_STK.
module regframe_map
    import regframe_pkg::*;
#(
    parameter int PHYS_STK = 128
) (
    input  logic [LOG_W-1:0]                          lidx,
    input  logic [$clog2(PHYS_STK)-1:0]               base,
    input  cnt_t                                      sof,
    input  cnt_t                                      sor,
    input  cnt_t                                      rrb,
    output logic [$clog2(NUM_GLOBALS+PHYS_STK)-1:0]   pidx,
    output logic                                      illegal
);
    localparam int BASE_W = $clog2(PHYS_STK);
    localparam int PHYS_W = $clog2(NUM_GLOBALS + PHYS_STK);
    localparam int SUM_W  = ((BASE_W > CNT_W) ? BASE_W : CNT_W) + 1;

    logic             is_global, in_rot;
    cnt_t             v, r;
    logic [CNT_W:0]   rsum;
    logic [SUM_W-1:0] psum;
    logic [BASE_W-1:0] off;

    // Virtual offset, rotated inside the rotating region.
    always_comb begin
        is_global = (lidx < LOG_W'(NUM_GLOBALS));
        v         = lidx - LOG_W'(NUM_GLOBALS);
        in_rot    = (v < sor);
        rsum      = {1'b0, v} + {1'b0, rrb};
        if (!in_rot)
            r = v;
        else if (rsum >= {1'b0, sor})
            r = CNT_W'(rsum - {1'b0, sor});
        else
            r = rsum[CNT_W-1:0];
        psum = SUM_W'(base) + SUM_W'(r);
    end

    // Pool wrap: plain truncation for power-of-two pools, else subtract.
    generate
        if ((PHYS_STK & (PHYS_STK - 1)) == 0) begin : g_pow2
            assign off = psum[BASE_W-1:0];
        end else begin : g_any
            assign off = (psum >= SUM_W'(PHYS_STK)) ? BASE_W'(psum - SUM_W'(PHYS_STK))
                                                   : BASE_W'(psum);
        end
    endgenerate

    // Final physical index and frame-bound check.
    always_comb begin
        pidx    = is_global ? PHYS_W'(lidx) : PHYS_W'(NUM_GLOBALS) + PHYS_W'(off);
        illegal = !is_global && (v >= sof);
    end
endmodule

// File: rtl/regframe_renamer.sv
// Top of the stacked and rotating register renamer.
// Assumes single-cycle command strobes and a 7-bit logical index.
module regframe_renamer #(
    parameter int PHYS_STK   = 128,
    parameter int SAVE_DEPTH = 8
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                do_alloc,
    input  logic                                                do_call,
    input  logic                                                do_return,
    input  logic                                                do_rotate,
    input  logic [6:0]                                          alloc_locals,
    input  logic [6:0]                                          alloc_outputs,
    input  logic [6:0]                                          alloc_rotating,
    input  logic [6:0]                                          lookup_idx,
    output logic [$clog2(regframe_pkg::NUM_GLOBALS+PHYS_STK)-1:0] phys_idx,
    output logic [6:0]                                          frame_size,
    output logic                                                illegal_reg,
    output logic                                                stack_overflow,
    output logic                                                stack_underflow
);
    import regframe_pkg::*;
    localparam int BASE_W = $clog2(PHYS_STK);
    localparam int PHYS_W = $clog2(NUM_GLOBALS + PHYS_STK);

    frame_cmd_e        cmd;
    logic [BASE_W-1:0] base;
    cnt_t              sof, sor, rrb;

    regframe_cmd_decode u_dec (
        .do_alloc  (do_alloc),
        .do_call   (do_call),
        .do_return (do_return),
        .do_rotate (do_rotate),
        .cmd       (cmd)
    );

    regframe_ctrl #(.PHYS_STK(PHYS_STK), .DEPTH(SAVE_DEPTH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd            (cmd),
        .alloc_locals   (alloc_locals),
        .alloc_outputs  (alloc_outputs),
        .alloc_rotating (alloc_rotating),
        .frame_base     (base),
        .frame_sof      (sof),
        .frame_sor      (sor),
        .frame_rrb      (rrb),
        .ovf_flag       (stack_overflow),
        .unf_flag       (stack_underflow)
    );

    regframe_map #(.PHYS_STK(PHYS_STK)) u_map (
        .lidx    (lookup_idx),
        .base    (base),
        .sof     (sof),
        .sor     (sor),
        .rrb     (rrb),
        .pidx    (phys_idx),
        .illegal (illegal_reg)
    );

    assign frame_size = sof;

    assert_global_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_idx < 7'd32) |-> (phys_idx == PHYS_W'(lookup_idx) && !illegal_reg));
    assert_stacked_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_idx >= 7'd32) |->
            (phys_idx >= PHYS_W'(NUM_GLOBALS) &&
             int'(phys_idx) < NUM_GLOBALS + PHYS_STK));
    assert_frame_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_size <= 7'(MAX_FRAME));
    assert_illegal_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_reg |-> (lookup_idx >= 7'd32));
endmodule

// File: tb/regframe_renamer_test.sv
// Self-checking bench: seeded random commands plus directed corners,
// compared against a behavioural frame model kept in the bench.
module regframe_renamer_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 128;
    localparam int D = 8;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       do_alloc = 0, do_call = 0, do_return = 0, do_rotate = 0;
    logic [6:0] alloc_locals = 0, alloc_outputs = 0, alloc_rotating = 0;
    logic [6:0] lookup_idx = 0;
    logic [7:0] phys_idx;
    logic [6:0] frame_size;
    logic       illegal_reg, stack_overflow, stack_underflow;

    int checks = 0;
    int fails  = 0;

    // model state
    int m_base = 0, m_sof = 0, m_sol = 0, m_sor = 0, m_rrb = 0, m_cnt = 0;
    int s_base[D], s_sof[D], s_sol[D], s_sor[D], s_rrb[D];
    bit e_ovf = 0, e_unf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regframe_renamer #(.PHYS_STK(P), .SAVE_DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n),
        .do_alloc(do_alloc), .do_call(do_call), .do_return(do_return), .do_rotate(do_rotate),
        .alloc_locals(alloc_locals), .alloc_outputs(alloc_outputs), .alloc_rotating(alloc_rotating),
        .lookup_idx(lookup_idx), .phys_idx(phys_idx), .frame_size(frame_size),
        .illegal_reg(illegal_reg), .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
    );

    function automatic int exp_phys(int idx);
        int v, r;
        if (idx < 32) return idx;          // R1
        v = idx - 32;
        r = (v < m_sor) ? (v + m_rrb) % m_sor : v;   // R5
        return 32 + (m_base + r) % P;      // R4
    endfunction

    function automatic bit exp_illegal(int idx);
        return (idx >= 32) && (idx - 32 >= m_sof);   // R10
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Update the model for one cycle of strobes (R11 priority).
    task automatic model_step(bit a, bit c, bit rt, bit ro, int lo, int ou, int rs);
        e_ovf = 0; e_unf = 0;
        if (a) begin
            if (lo + ou <= 96 && rs <= lo + ou) begin        // R3
                m_sof = lo + ou; m_sol = lo; m_sor = rs; m_rrb = 0;
            end
        end else if (c) begin
            if (m_cnt == D) e_ovf = 1;                      // R8
            else begin                                       // R6
                s_base[m_cnt] = m_base; s_sof[m_cnt] = m_sof; s_sol[m_cnt] = m_sol;
                s_sor[m_cnt] = m_sor;   s_rrb[m_cnt] = m_rrb; m_cnt++;
                m_base = (m_base + m_sol) % P;
                m_sof = m_sof - m_sol; m_sol = 0; m_sor = 0; m_rrb = 0;
            end
        end else if (rt) begin
            if (m_cnt == 0) e_unf = 1;                      // R9
            else begin                                       // R7
                m_cnt--;
                m_base = s_base[m_cnt]; m_sof = s_sof[m_cnt]; m_sol = s_sol[m_cnt];
                m_sor = s_sor[m_cnt];   m_rrb = s_rrb[m_cnt];
            end
        end else if (ro) begin
            if (m_sor != 0) m_rrb = (m_rrb == 0) ? m_sor - 1 : m_rrb - 1;   // R5
        end
    endtask

    task automatic probe(int idx, string req);
        @(negedge clk);
        lookup_idx = 7'(idx);
        #1;
        check(req, int'(phys_idx), exp_phys(idx));
        check("R10", int'(illegal_reg), int'(exp_illegal(idx)));
    endtask

    // Drive one command cycle and check flags and frame size (R12).
    task automatic apply(bit a, bit c, bit rt, bit ro, int lo, int ou, int rs);
        @(negedge clk);
        do_alloc = a; do_call = c; do_return = rt; do_rotate = ro;
        alloc_locals = 7'(lo); alloc_outputs = 7'(ou); alloc_rotating = 7'(rs);
        model_step(a, c, rt, ro, lo, ou, rs);
        @(negedge clk);
        do_alloc = 0; do_call = 0; do_return = 0; do_rotate = 0;
        check("R8 overflow flag", int'(stack_overflow), int'(e_ovf));
        check("R9 underflow flag", int'(stack_underflow), int'(e_unf));
        check("R3 frame size", int'(frame_size), m_sof);
    endtask

    task automatic probe_frame();
        probe($urandom_range(31, 0), "R1");
        probe(32, "R4");
        if (m_sof > 0) probe(31 + m_sof, "R4");
        if (m_sor > 0) probe(31 + m_sor, "R5");
        if (m_sof < 96) probe(32 + m_sof, "R10");
        probe($urandom_range(127, 32), "R4");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 frame size", int'(frame_size), 0);
        check("R2 overflow", int'(stack_overflow), 0);
        check("R2 underflow", int'(stack_underflow), 0);
        probe(5, "R1");
        probe(32, "R2");

        // R3 alloc and R5 rotation with wrap
        apply(1, 0, 0, 0, 10, 6, 8);
        probe_frame();
        apply(0, 0, 0, 1, 0, 0, 0);
        probe(32, "R5");
        probe(40, "R5");
        apply(0, 0, 0, 1, 0, 0, 0);
        probe(39, "R5");
        // ignored allocs (R3)
        apply(1, 0, 0, 0, 60, 50, 0);
        apply(1, 0, 0, 0, 2, 2, 5);
        probe(33, "R3");
        // call and return (R6, R7)
        apply(0, 1, 0, 0, 0, 0, 0);
        probe(32, "R6");
        apply(0, 0, 1, 0, 0, 0, 0);
        probe(32, "R7");
        probe(38, "R7");
        // underflow (R9) then priority (R11)
        apply(0, 0, 1, 0, 0, 0, 0);
        apply(1, 1, 1, 1, 4, 4, 2);
        apply(0, 0, 1, 0, 0, 0, 0);
        probe(33, "R11");
        // fill the save stack and overflow (R8)
        for (int i = 0; i < D; i++) begin
            apply(1, 0, 0, 0, 90, 6, 4);
            apply(0, 1, 0, 0, 0, 0, 0);
            probe(80, "R6");
        end
        apply(0, 1, 0, 0, 0, 0, 0);
        probe(35, "R8");
        apply(0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < D; i++) begin
            apply(0, 0, 1, 0, 0, 0, 0);
            probe_frame();
        end
        apply(0, 0, 1, 0, 0, 0, 0);

        // seeded random mix
        for (int n = 0; n < 500; n++) begin
            int op, lo, ou, rs;
            op = $urandom_range(9, 0);
            lo = $urandom_range(60, 0);
            ou = $urandom_range(50, 0);
            rs = $urandom_range(lo + ou + 2, 0);
            case (op)
                0, 1:    apply(1, 0, 0, 0, lo, ou, rs);
                2, 3:    apply(0, 1, 0, 0, 0, 0, 0);
                4, 5:    apply(0, 0, 1, 0, 0, 0, 0);
                6, 7, 8: apply(0, 0, 0, 1, 0, 0, 0);
                default: apply(($urandom_range(1, 0) == 1), 1'b1, 1'b1, 1'b1, lo, ou, rs);
            endcase
            probe_frame();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule